// File: doc/BRIEF.md
# I2C channel-select switch controller

This block is an I2C target that decides which downstream bus segments are joined to the upstream bus. It watches the upstream SCL and SDA lines through synchronisers running on the system clock. It pulls SDA low through an open-drain enable whenever it acknowledges or returns a zero bit. It answers to one 7-bit address. The upper four bits of that address are fixed and the lower three come from strap pins, so up to eight of these controllers can share one bus.

The controller writes a single mask byte after the address. Each bit of the mask turns on the external pass gate of one channel, and any mix of channels may be on together. A written mask first goes into a pending holder. It is copied to the channel enables only when a STOP is seen, so segments are joined only while the upstream bus is idle high. When several bytes arrive in one transfer, the last one received is kept. A repeated START throws away a mask that has not yet been committed. A read returns the committed mask. All channels are off after reset.

Top module: `segsel_switch`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth SCL pulse) only an address byte whose upper seven bits equal {4'b1110, strap_in[2:0]}. Bit 0 of the address byte is the direction: 0 = write, 1 = read. Any other address gets no acknowledge and no further response until the next START.
- R2: After an acknowledged write address, each following data byte is acknowledged and becomes the pending mask.
- R3: Once committed, bit i of the mask drives chan_en[i], where 1 = channel connected. Every one of the 256 combinations is allowed, including several bits at once.
- R4: chan_en changes only on the clock after a STOP is detected. It keeps its old value through the data bytes and the acknowledges.
- R5: When several data bytes are written before one STOP, the byte received last is the one committed.
- R6: A STOP commits only if at least one data byte was acknowledged since the last START. A repeated START discards any uncommitted pending mask, and an address-only write leaves chan_en unchanged.
- R7: A read returns the committed mask, MSB first. It sends the mask again for each byte that the controller acknowledges and releases SDA once the controller does not acknowledge.
- R8: While reset is asserted and after it is released, chan_en is all zero and SDA is released.
- R9: The target changes its SDA drive only while the synchronised SCL is low, and it releases SDA after any START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Upstream SCL line level |
| sda_in | input | 1 | Upstream SDA line level, including this target's own drive |
| strap_in | input | 3 | Strap pins giving the low address bits |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls upstream SDA low |
| chan_en | output | 8 | One pass-gate enable per downstream channel |

## Verification
The bound checker watches four rules on every cycle: channel enables move only right after a detected STOP, the SDA drive changes only while the synchronised SCL is low, SDA is released after every START, and the enables stay zero during reset. Whether the right address is acknowledged, whether the last byte wins, whether a repeated START discards the pending mask, and whether read data is correct bit by bit depend on whole bus transactions. Only the bench scenarios show these, through a full sweep of all 128 addresses, a sweep of every strap setting, and a set of mask patterns each written and then read back.

// File: rtl/segsel_pkg.sv
package segsel_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } seg_state_e;

    typedef struct packed {
        seg_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   tx;
        logic                rd;
        logic                oe;
        logic                hack;
    } eng_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

endpackage

// File: rtl/segsel_sync.sv
module segsel_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/segsel_linecond.sv
module segsel_linecond
    import segsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    line_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
        scl_rise   = scl_s & ~prev_q.scl;
        scl_fall   = ~scl_s & prev_q.scl;
        start_p    = prev_q.scl & scl_s & prev_q.sda & ~sda_s;
        stop_p     = prev_q.scl & scl_s & ~prev_q.sda & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/segsel_engine.sv
module segsel_engine
    import segsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_t q, d;

    always_comb begin
        d       = q;
        wr_stb  = 1'b0;
        wr_byte = q.sh;
        if (stop_p) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_p) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (q.sh[BYTE_W-1:1] == dev_addr) begin
                            d.st = ST_ADDR_ACK;
                            d.oe = 1'b1;
                            d.rd = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.tx = rd_byte;
                            d.oe = ~rd_byte[BYTE_W-1];
                            d.st = ST_RD;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.oe   = 1'b1;
                        d.st   = ST_WR_ACK;
                        wr_stb = 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_RD_ACK;
                        end else begin
                            d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.hack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.hack) begin
                            d.tx  = rd_byte;
                            d.oe  = ~rd_byte[BYTE_W-1];
                            d.cnt = '0;
                            d.st  = ST_RD;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, tx: '0, rd: 1'b0, oe: 1'b0, hack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/segsel_maskreg.sv
module segsel_maskreg
    import segsel_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [NUM_CH-1:0] active
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic              pend_vld;
        logic [NUM_CH-1:0] act;
    } mask_t;

    mask_t q, d;

    always_comb begin
        d = q;
        if (wr_stb) begin
            d.pend     = wr_byte[NUM_CH-1:0];
            d.pend_vld = 1'b1;
        end
        if (start_p) begin
            d.pend_vld = 1'b0;
        end
        if (stop_p) begin
            if (q.pend_vld) d.act = q.pend;
            d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.act;
endmodule

// File: rtl/segsel_switch.sv
module segsel_switch
    import segsel_pkg::*;
#(
    parameter int                       NUM_CH      = 8,
    parameter int                       STRAP_W     = 3,
    parameter int                       SYNC_STAGES = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = 'b1110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               sda_pull_low,
    output logic [NUM_CH-1:0]  chan_en
);
    logic [1:0]        raw_lines, sync_lines;
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_p, stop_p;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;
    logic [NUM_CH-1:0] active;
    logic [ADDR_W-1:0] dev_addr;

    assign raw_lines = {scl_in, sda_in};
    assign scl_s     = sync_lines[1];
    assign sda_s     = sync_lines[0];
    assign dev_addr  = {ADDR_FIXED, strap_in};

    always_comb begin
        rd_byte               = '0;
        rd_byte[NUM_CH-1:0]   = active;
    end

    segsel_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .dout  (sync_lines)
    );

    segsel_linecond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    segsel_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .sda_s    (sda_s),
        .dev_addr (dev_addr),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_pull_low),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte)
    );

    segsel_maskreg #(.NUM_CH(NUM_CH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_p (start_p),
        .stop_p  (stop_p),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .active  (active)
    );

    assign chan_en = active;
endmodule

// File: rtl/segsel_chk.sv
module segsel_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_p,
    input logic              stop_p,
    input logic              sda_oe,
    input logic [NUM_CH-1:0] chan_en
);
    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_off_chk: assert (chan_en == '0 && !sda_oe)
                else $error("enables or SDA drive active during reset");
        end
    end

    // R4
    enable_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(stop_p))
        else $error("channel enables moved without a STOP");

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s))
        else $error("SDA drive changed while SCL high");

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_oe)
        else $error("SDA still driven after START");
endmodule

bind segsel_switch segsel_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .start_p (start_p),
    .stop_p  (stop_p),
    .sda_oe  (sda_pull_low),
    .chan_en (chan_en)
);

// File: tb/segsel_switch_bench.sv
`timescale 1ns/1ps
module segsel_switch_bench;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap = 3'd5;
    logic       pull_low;
    logic [7:0] chan;
    wire        sda_line = sda_drv & ~pull_low;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    segsel_switch u_segsel_switch (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_line),
        .strap_in     (strap),
        .sda_pull_low (pull_low),
        .chan_en      (chan)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [6:0] dev_of(input logic [2:0] s);
        return {4'b1110, s};
    endfunction

    task automatic bus_start();
        if (!scl) begin
            sda_drv = 1'b1; tick(Q);
            scl = 1'b1;     tick(Q);
        end
        sda_drv = 1'b0; tick(Q);
        scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl = 1'b1;     tick(Q);
        sda_drv = 1'b1; tick(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_drv = b;    tick(Q);
        scl = 1'b1;     tick(Q);
        seen = sda_line; tick(Q);
        scl = 1'b0;     tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic write_mask(input logic [7:0] m);
        logic a;
        bus_start();
        send_byte({dev_of(strap), 1'b0}, a);
        check("R1 write address ack", int'(a), 1);
        send_byte(m, a);
        check("R2 data byte ack", int'(a), 1);
        bus_stop();
    endtask

    initial begin : main
        logic       a;
        logic [7:0] v;
        logic [7:0] cur;
        logic [7:0] m;

        tick(5);
        check("R8 enables off in reset", int'(chan), 0);
        rst_n = 1'b1;
        tick(5);
        check("R8 enables off after reset", int'(chan), 0);
        check("R8 SDA released after reset", int'(pull_low), 0);

        // R1: every address with strap 5, no data bytes (R6 address-only)
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            check("R1 address sweep ack", int'(a), int'(7'(ad) == dev_of(3'd5)));
            bus_stop();
            check("R6 address-only leaves enables", int'(chan), 0);
        end

        // R1 strap sweep: own address acked, neighbour's not
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            tick(4);
            m = 8'((s * 29) + 3);
            write_mask(m);
            check("R3 strap sweep commit", int'(chan), int'(m));
            bus_start();
            send_byte({dev_of(3'(s + 1)), 1'b0}, a);
            check("R1 neighbour address no ack", int'(a), 0);
            send_byte(8'hA5, a);
            bus_stop();
            check("R1 foreign write ignored", int'(chan), int'(m));
        end
        strap = 3'd5;
        tick(4);

        // R3/R4/R7: mask patterns
        cur = chan;
        for (int k = 0; k < 22; k++) begin
            if (k < 8)       m = 8'(1 << k);
            else if (k == 8) m = 8'h00;
            else if (k == 9) m = 8'hFF;
            else             m = 8'((k * 53) + 17);
            bus_start();
            send_byte({dev_of(strap), 1'b0}, a);
            check("R1 ack", int'(a), 1);
            send_byte(m, a);
            check("R2 data ack", int'(a), 1);
            check("R4 held before STOP", int'(chan), int'(cur));
            bus_stop();
            check("R3 mask applied", int'(chan), int'(m));
            cur = m;
            bus_start();
            send_byte({dev_of(strap), 1'b1}, a);
            check("R7 read address ack", int'(a), 1);
            recv_byte(1'b0, v);
            check("R7 read data", int'(v), int'(m));
            check("R7 SDA released after NACK", int'(pull_low), 0);
            bus_stop();
        end

        // R5: last byte wins
        bus_start();
        send_byte({dev_of(strap), 1'b0}, a);
        send_byte(8'h3C, a);
        send_byte(8'h81, a);
        send_byte(8'h5A, a);
        check("R5 third byte ack", int'(a), 1);
        check("R4 held through bytes", int'(chan), int'(cur));
        bus_stop();
        check("R5 last byte committed", int'(chan), 8'h5A);
        cur = 8'h5A;

        // R6: repeated START discards pending; R7 multi-byte read
        bus_start();
        send_byte({dev_of(strap), 1'b0}, a);
        send_byte(8'hC3, a);
        bus_start();
        send_byte({dev_of(strap), 1'b1}, a);
        recv_byte(1'b1, v);
        check("R7 first read byte", int'(v), int'(cur));
        recv_byte(1'b0, v);
        check("R7 second read byte after ACK", int'(v), int'(cur));
        check("R7 released on NACK", int'(pull_low), 0);
        bus_stop();
        check("R6 pending discarded by repeated START", int'(chan), int'(cur));

        // R6: repeated START then address-only write
        bus_start();
        send_byte({dev_of(strap), 1'b0}, a);
        send_byte(8'h0F, a);
        bus_start();
        send_byte({dev_of(strap), 1'b0}, a);
        bus_stop();
        check("R6 no commit without new data", int'(chan), int'(cur));

        // R8: reset in operation
        tick(3);
        rst_n = 1'b0;
        tick(3);
        check("R8 reset clears enables", int'(chan), 0);
        rst_n = 1'b1;
        tick(5);
        check("R8 enables off after re-release", int'(chan), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule